// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block holds the configuration registers of a power-management PCI function. It places two relocatable I/O windows: a 128-byte window for the power-management register set and a 16-byte window for an SMBus controller. Software programs each window's base through a 32-bit configuration access port with per-byte enables. Each window is switched on by its own bit in a separate control register. For an incoming 16-bit I/O address the block reports, per window, whether the address falls inside an enabled window.

The block also keeps the PM1 event status and enable words. Status bits are set by event pulses and cleared by writing ones. From the enabled status bits the block derives a level system control interrupt (SCI) and a signal that arms the timer overflow. The timer counter, the SMBus host and the PCI bus protocol are handled by neighbouring blocks.

Top module: `pm_io_decode`

## Requirements
- R1: After reset the dwords at configuration offsets 0x48 and 0x90 read 0x00000001. The dwords at 0x40 and 0xD0 read 0. The dword at 0x3C reads 0x00000100, with the interrupt-pin byte at 0x3D equal to 1. Both window enables and both hit outputs are 0.
- R2: A write that touches the PM base dword (offset 0x48) keeps only the bits in mask 0x0000FF80. It then forces bit 0 to 1. `pm_base_o` shows the masked base, with bit 0 clear.
- R3: Bit 7 of configuration byte 0x41 (bit 15 of dword 0x40) drives `pm_en_o`. The whole byte reads back as written.
- R4: A write that touches the SMBus base dword (offset 0x90) keeps only the bits in mask 0x0000FFF0 and forces bit 0 to 1.
- R5: Configuration byte 0xD2 (bits 23:16 of dword 0xD0) stores only its low 4 bits. Bit 0 of that byte drives `smb_en_o`.
- R6: `pm_hit_o` is 1 exactly when `pm_en_o` is 1 and address bits 15:7 equal the PM base. `smb_hit_o` is 1 exactly when `smb_en_o` is 1 and address bits 15:4 equal the SMBus base.
- R7: Base, enable and read-back values change on the clock edge that accepts the write, so they are visible in the cycle after the write.
- R8: A configuration write changes only the bytes whose byte enable is 1. Bit `cfg_be_i[k]` selects `cfg_wdata_i[8k+7:8k]`.
- R9: A 1 on `sts_set_i[k]` sets status bit k. A 1 on `sts_clr_i[k]` clears it. When both are 1 in the same cycle, set wins.
- R10: `sci_o` is 1 when (status AND enable) has any of these bits set: bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). Other bits have no effect.
- R11: `sci_o` stays 0 while the interrupt-pin byte at 0x3D is zero.
- R12: `tmr_arm_o` equals enable bit 0 AND NOT status bit 0.
- R13: Reads of dword offsets that hold none of these registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the addressed dword (combinational) |
| io_addr_i | input | 16 | I/O address to decode |
| pm_base_o | output | 16 | PM window base |
| pm_en_o | output | 1 | PM window enable |
| pm_hit_o | output | 1 | Address is inside the enabled PM window |
| smb_base_o | output | 16 | SMBus window base |
| smb_en_o | output | 1 | SMBus window enable |
| smb_hit_o | output | 1 | Address is inside the enabled SMBus window |
| sts_set_i | input | 16 | PM1 status set pulses |
| sts_clr_i | input | 16 | PM1 status write-one-to-clear |
| en_we_i | input | 1 | PM1 enable write strobe |
| en_wdata_i | input | 16 | PM1 enable write data |
| pm1_sts_o | output | 16 | PM1 status |
| pm1_en_o | output | 16 | PM1 enable |
| sci_o | output | 1 | System control interrupt level |
| tmr_arm_o | output | 1 | Timer overflow arm |

## Verification
The assertions assume that every input is at a known value at each rising clock edge. They also assume that a configuration write of the base registers becomes visible on the following edge, with no other write to the same dword in that cycle. The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. It drives idle values on every input outside a task, so no assertion sees an unknown or half-formed access.

// File: rtl/pm_io_pkg.sv
package pm_io_pkg;
  localparam int CFG_DW  = 32;
  localparam int CFG_AW  = 6;
  localparam int EVT_W   = 16;

  localparam logic [CFG_AW-1:0] DW_INTPIN  = 6'h0F;
  localparam logic [CFG_AW-1:0] DW_PMCTL   = 6'h10;
  localparam logic [CFG_AW-1:0] DW_PMBASE  = 6'h12;
  localparam logic [CFG_AW-1:0] DW_SMBBASE = 6'h24;
  localparam logic [CFG_AW-1:0] DW_SMBCTL  = 6'h34;

  localparam int TMR_BIT = 0;
  localparam logic [EVT_W-1:0] SCI_SRC_MASK = 16'h0521;

  function automatic logic [CFG_DW-1:0] byte_merge(
    input logic [CFG_DW-1:0] old_v,
    input logic [CFG_DW-1:0] new_v,
    input logic [CFG_DW/8-1:0] be);
    logic [CFG_DW-1:0] r;
    for (int k = 0; k < CFG_DW/8; k++)
      r[8*k +: 8] = be[k] ? new_v[8*k +: 8] : old_v[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_io_pkg::*;
#(
  parameter int IO_AW       = 16,
  parameter int PM_WIN_LG   = 7,
  parameter int SMB_WIN_LG  = 4,
  parameter logic [7:0] INT_PIN_RST = 8'h01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CFG_AW-1:0]   addr_i,
  input  logic [CFG_DW/8-1:0] be_i,
  input  logic [CFG_DW-1:0]   wdata_i,
  output logic [CFG_DW-1:0]   rdata_o,
  output logic [7:0]          int_pin_o,
  output logic [7:0]          pm_ctl_o,
  output logic [CFG_DW-1:0]   pm_base_o,
  output logic [CFG_DW-1:0]   smb_base_o,
  output logic [3:0]          smb_ctl_o
);
  localparam logic [CFG_DW-1:0] IO_SPAN  = (CFG_DW'(1) << IO_AW) - CFG_DW'(1);
  localparam logic [CFG_DW-1:0] PM_MASK  = IO_SPAN & ~((CFG_DW'(1) << PM_WIN_LG) - CFG_DW'(1));
  localparam logic [CFG_DW-1:0] SMB_MASK = IO_SPAN & ~((CFG_DW'(1) << SMB_WIN_LG) - CFG_DW'(1));

  logic [7:0]        int_pin_q, pm_ctl_q;
  logic [3:0]        smb_ctl_q;
  logic [CFG_DW-1:0] pm_base_q, smb_base_q;
  logic [CFG_DW-1:0] pm_base_d, smb_base_d;

  assign pm_base_d  = (byte_merge(pm_base_q,  wdata_i, be_i) & PM_MASK)  | CFG_DW'(1);
  assign smb_base_d = (byte_merge(smb_base_q, wdata_i, be_i) & SMB_MASK) | CFG_DW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_pin_q  <= INT_PIN_RST;
      pm_ctl_q   <= '0;
      smb_ctl_q  <= '0;
      pm_base_q  <= CFG_DW'(1);
      smb_base_q <= CFG_DW'(1);
    end else if (we_i) begin
      unique case (addr_i)
        DW_INTPIN:  if (be_i[1]) int_pin_q <= wdata_i[15:8];
        DW_PMCTL:   if (be_i[1]) pm_ctl_q  <= wdata_i[15:8];
        DW_SMBCTL:  if (be_i[2]) smb_ctl_q <= wdata_i[19:16];
        DW_PMBASE:  if (|be_i)   pm_base_q  <= pm_base_d;
        DW_SMBBASE: if (|be_i)   smb_base_q <= smb_base_d;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      DW_INTPIN:  rdata_o[15:8]  = int_pin_q;
      DW_PMCTL:   rdata_o[15:8]  = pm_ctl_q;
      DW_SMBCTL:  rdata_o[19:16] = smb_ctl_q;
      DW_PMBASE:  rdata_o        = pm_base_q;
      DW_SMBBASE: rdata_o        = smb_base_q;
      default: ;
    endcase
  end

  assign int_pin_o  = int_pin_q;
  assign pm_ctl_o   = pm_ctl_q;
  assign smb_ctl_o  = smb_ctl_q;
  assign pm_base_o  = pm_base_q;
  assign smb_base_o = smb_base_q;
endmodule

// File: rtl/pm_io_window.sv
module pm_io_window #(
  parameter int IO_AW  = 16,
  parameter int WIN_LG = 7
) (
  input  logic [IO_AW-1:0] base_i,
  input  logic             en_i,
  input  logic [IO_AW-1:0] addr_i,
  output logic             hit_o
);
  localparam logic [IO_AW-1:0] CMP_MASK = ~((IO_AW'(1) << WIN_LG) - IO_AW'(1));

  assign hit_o = en_i && (((addr_i ^ base_i) & CMP_MASK) == '0);
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
  import pm_io_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [EVT_W-1:0] en_wdata_i,
  input  logic             pin_used_i,
  output logic [EVT_W-1:0] sts_o,
  output logic [EVT_W-1:0] en_o,
  output logic             sci_o,
  output logic             arm_o
);
  logic [EVT_W-1:0] sts_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = pin_used_i && |(sts_q & en_q & SCI_SRC_MASK);
  assign arm_o = en_q[TMR_BIT] && !sts_q[TMR_BIT];
endmodule

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import pm_io_pkg::*;
#(
  parameter int IO_AW      = 16,
  parameter int PM_WIN_LG  = 7,
  parameter int SMB_WIN_LG = 4,
  parameter logic [7:0] INT_PIN_RST = 8'h01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [CFG_DW/8-1:0] cfg_be_i,
  input  logic [CFG_DW-1:0]   cfg_wdata_i,
  output logic [CFG_DW-1:0]   cfg_rdata_o,
  input  logic [IO_AW-1:0]    io_addr_i,
  output logic [IO_AW-1:0]    pm_base_o,
  output logic                pm_en_o,
  output logic                pm_hit_o,
  output logic [IO_AW-1:0]    smb_base_o,
  output logic                smb_en_o,
  output logic                smb_hit_o,
  input  logic [EVT_W-1:0]    sts_set_i,
  input  logic [EVT_W-1:0]    sts_clr_i,
  input  logic                en_we_i,
  input  logic [EVT_W-1:0]    en_wdata_i,
  output logic [EVT_W-1:0]    pm1_sts_o,
  output logic [EVT_W-1:0]    pm1_en_o,
  output logic                sci_o,
  output logic                tmr_arm_o
);
  localparam int NWIN = 2;

  logic [7:0]        int_pin;
  logic [7:0]        pm_ctl;
  logic [3:0]        smb_ctl;
  logic [CFG_DW-1:0] pm_base_raw, smb_base_raw;

  pm_cfg_regs #(
    .IO_AW(IO_AW), .PM_WIN_LG(PM_WIN_LG), .SMB_WIN_LG(SMB_WIN_LG), .INT_PIN_RST(INT_PIN_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .int_pin_o(int_pin), .pm_ctl_o(pm_ctl),
    .pm_base_o(pm_base_raw), .smb_base_o(smb_base_raw), .smb_ctl_o(smb_ctl)
  );

  // bit 0 of each base register is an indicator, not an address bit
  logic [IO_AW-1:0] win_base [NWIN];
  logic             win_en   [NWIN];
  logic             win_hit  [NWIN];

  assign win_base[0] = {pm_base_raw[IO_AW-1:1], 1'b0};
  assign win_base[1] = {smb_base_raw[IO_AW-1:1], 1'b0};
  assign win_en[0]   = pm_ctl[7];
  assign win_en[1]   = smb_ctl[0];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int LG = (g == 0) ? PM_WIN_LG : SMB_WIN_LG;
    pm_io_window #(.IO_AW(IO_AW), .WIN_LG(LG)) u_win (
      .base_i(win_base[g]), .en_i(win_en[g]), .addr_i(io_addr_i), .hit_o(win_hit[g])
    );
  end

  assign pm_base_o  = win_base[0];
  assign smb_base_o = win_base[1];
  assign pm_en_o    = win_en[0];
  assign smb_en_o   = win_en[1];
  assign pm_hit_o   = win_hit[0];
  assign smb_hit_o  = win_hit[1];

  pm_sci_gen u_sci (
    .clk_i, .rst_ni,
    .set_i(sts_set_i), .clr_i(sts_clr_i),
    .en_we_i, .en_wdata_i,
    .pin_used_i(int_pin != 8'h00),
    .sts_o(pm1_sts_o), .en_o(pm1_en_o),
    .sci_o, .arm_o(tmr_arm_o)
  );
endmodule

// File: rtl/pm_io_decode_chk.sv
module pm_io_decode_chk
  import pm_io_pkg::*;
#(
  parameter int IO_AW = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic [CFG_AW-1:0]   cfg_addr_i,
  input logic [CFG_DW/8-1:0] cfg_be_i,
  input logic [CFG_DW-1:0]   cfg_wdata_i,
  input logic [IO_AW-1:0]    pm_base_o,
  input logic                pm_en_o,
  input logic                pm_hit_o,
  input logic                smb_en_o,
  input logic                smb_hit_o,
  input logic [EVT_W-1:0]    sts_set_i,
  input logic [EVT_W-1:0]    pm1_sts_o,
  input logic [EVT_W-1:0]    pm1_en_o,
  input logic                sci_o
);
  // R7
  pm_base_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == DW_PMBASE && cfg_be_i[1])
      |=> pm_base_o[IO_AW-1:8] == $past(cfg_wdata_i[IO_AW-1:8]));

  // R6
  pm_hit_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> pm_en_o);

  // R6
  smb_hit_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_hit_o |-> smb_en_o);

  // R5
  smb_en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == DW_SMBCTL && cfg_be_i[2])
      |=> smb_en_o == $past(cfg_wdata_i[16]));

  // R9
  sts_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_set_i != '0) |=> ((pm1_sts_o & $past(sts_set_i)) == $past(sts_set_i)));

  // R10
  sci_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> ((pm1_sts_o & pm1_en_o & SCI_SRC_MASK) != '0));
endmodule

bind pm_io_decode pm_io_decode_chk #(.IO_AW(IO_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i),
  .pm_base_o(pm_base_o), .pm_en_o(pm_en_o), .pm_hit_o(pm_hit_o),
  .smb_en_o(smb_en_o), .smb_hit_o(smb_hit_o),
  .sts_set_i(sts_set_i), .pm1_sts_o(pm1_sts_o), .pm1_en_o(pm1_en_o), .sci_o(sci_o)
);

// File: tb/pm_io_decode_test.sv
module pm_io_decode_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [15:0] io_addr_i = '0;
  logic [15:0] pm_base_o, smb_base_o;
  logic        pm_en_o, pm_hit_o, smb_en_o, smb_hit_o;
  logic [15:0] sts_set_i = '0, sts_clr_i = '0;
  logic        en_we_i = 1'b0;
  logic [15:0] en_wdata_i = '0;
  logic [15:0] pm1_sts_o, pm1_en_o;
  logic        sci_o, tmr_arm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  pm_io_decode uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = off[7:2]; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_be_i = '0; cfg_wdata_i = '0;
  endtask

  task automatic cfg_rd(input string tag, input logic [7:0] off, input logic [31:0] exp);
    cfg_addr_i = off[7:2];
    #1;
    chk(tag, cfg_rdata_o, exp);
  endtask

  task automatic hit(input string tag, input logic [15:0] a, input logic pm_e, input logic smb_e);
    io_addr_i = a;
    #1;
    chk(tag, {30'b0, pm_hit_o, smb_hit_o}, {30'b0, pm_e, smb_e});
  endtask

  task automatic evt(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk_i);
    sts_set_i = s; sts_clr_i = c;
    @(negedge clk_i);
    sts_set_i = '0; sts_clr_i = '0;
  endtask

  task automatic en_wr(input logic [15:0] v);
    @(negedge clk_i);
    en_we_i = 1'b1; en_wdata_i = v;
    @(negedge clk_i);
    en_we_i = 1'b0;
  endtask

  task automatic t_reset;
    cfg_rd("R1 pm base", 8'h48, 32'h0000_0001);
    cfg_rd("R1 smb base", 8'h90, 32'h0000_0001);
    cfg_rd("R1 pm ctl", 8'h40, 32'h0);
    cfg_rd("R1 smb ctl", 8'hD0, 32'h0);
    cfg_rd("R1 int pin", 8'h3C, 32'h0000_0100);
    chk("R1 enables", {pm_en_o, smb_en_o}, 32'h0);
    hit("R1 hits", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_pm_base;
    cfg_wr(8'h48, 4'hF, 32'hFFFF_FFFF);
    cfg_rd("R2 all ones", 8'h48, 32'h0000_FF81);
    chk("R2 base out", pm_base_o, 32'hFF80);
    cfg_wr(8'h48, 4'hF, 32'h1234_5678);
    cfg_rd("R2 pattern", 8'h48, 32'h0000_5601);
    cfg_wr(8'h48, 4'h2, 32'h0000_AB00);
    cfg_rd("R8 byte1 only", 8'h48, 32'h0000_AB01);
    cfg_wr(8'h48, 4'h4, 32'h00FF_0000);
    cfg_rd("R8 masked byte", 8'h48, 32'h0000_AB01);
  endtask

  task automatic t_pm_win;
    hit("R6 pm disabled", 16'hAB00, 1'b0, 1'b0);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 6'h10; cfg_be_i = 4'h2; cfg_wdata_i = 32'h0000_8000;
    #1 chk("R7 before edge", pm_en_o, 1'b0);
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_be_i = '0;
    chk("R7 after edge", pm_en_o, 1'b1);
    cfg_rd("R3 ctl byte", 8'h40, 32'h0000_8000);
    hit("R6 pm low", 16'hAB00, 1'b1, 1'b0);
    hit("R6 pm top", 16'hAB7F, 1'b1, 1'b0);
    hit("R6 pm above", 16'hAB80, 1'b0, 1'b0);
    hit("R6 pm below", 16'hAAFF, 1'b0, 1'b0);
    cfg_wr(8'h40, 4'h2, 32'h0000_7F00);
    chk("R3 disable", pm_en_o, 1'b0);
    hit("R6 pm off", 16'hAB00, 1'b0, 1'b0);
  endtask

  task automatic t_smb;
    cfg_wr(8'h90, 4'hF, 32'hFFFF_FFFF);
    cfg_rd("R4 all ones", 8'h90, 32'h0000_FFF1);
    cfg_wr(8'h90, 4'hF, 32'h0000_C05A);
    cfg_rd("R4 pattern", 8'h90, 32'h0000_C051);
    chk("R4 base out", smb_base_o, 32'hC050);
    cfg_wr(8'hD0, 4'h4, 32'h00FF_0000);
    cfg_rd("R5 low nibble", 8'hD0, 32'h000F_0000);
    chk("R5 enable", smb_en_o, 1'b1);
    hit("R6 smb low", 16'hC050, 1'b0, 1'b1);
    hit("R6 smb top", 16'hC05F, 1'b0, 1'b1);
    hit("R6 smb above", 16'hC060, 1'b0, 1'b0);
    cfg_wr(8'hD0, 4'hB, 32'hFF00_FFFF);
    cfg_rd("R8 other bytes", 8'hD0, 32'h000F_0000);
    cfg_wr(8'hD0, 4'h4, 32'h00FE_0000);
    chk("R5 disable", smb_en_o, 1'b0);
  endtask

  task automatic t_sci;
    en_wr(16'hFFFF);
    evt(16'h0002, 16'h0);
    chk("R9 set", pm1_sts_o, 32'h0002);
    chk("R10 non source", sci_o, 1'b0);
    en_wr(16'h0400);
    evt(16'h0400, 16'h0);
    chk("R10 rtc", sci_o, 1'b1);
    evt(16'h0, 16'h0400);
    chk("R9 w1c", pm1_sts_o, 32'h0002);
    chk("R10 cleared", sci_o, 1'b0);
    evt(16'h0020, 16'h0020);
    chk("R9 set wins", pm1_sts_o, 32'h0022);
    en_wr(16'h0100);
    cfg_wr(8'h3C, 4'h2, 32'h0);
    evt(16'h0100, 16'h0);
    chk("R11 pin zero", sci_o, 1'b0);
    cfg_wr(8'h3C, 4'h2, 32'h0000_0100);
    chk("R11 pin restored", sci_o, 1'b1);
    evt(16'h0, 16'hFFFF);
  endtask

  task automatic t_tmr;
    en_wr(16'h0001);
    chk("R12 armed", tmr_arm_o, 1'b1);
    evt(16'h0001, 16'h0);
    chk("R12 status set", tmr_arm_o, 1'b0);
    chk("R10 timer", sci_o, 1'b1);
    evt(16'h0, 16'h0001);
    en_wr(16'h0000);
    chk("R12 disabled", tmr_arm_o, 1'b0);
  endtask

  task automatic t_unmapped;
    cfg_rd("R13 off 0x00", 8'h00, 32'h0);
    cfg_rd("R13 off 0x44", 8'h44, 32'h0);
    cfg_rd("R13 off 0xFC", 8'hFC, 32'h0);
  endtask

  initial begin
    fork
      begin
        #10 rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_pm_base();
        t_pm_win();
        t_smb();
        t_sci();
        t_tmr();
        t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule